// File: doc/BRIEF.md
# Serial Receive Path with Error-Tagged Queue

This block is the receive half of one asynchronous serial channel. A 16x oversampling enable, produced elsewhere, paces a small state machine that finds the start bit, confirms it at mid-bit, collects eight data bits least significant first, and then checks an optional parity bit and the stop bit. Each finished character is stored together with three error flags: parity error, framing error and line break. Because the flags are stored with the byte, a host that reads the queue always sees the flags for the byte it is reading.

The store is a 64-entry queue of 11-bit words. The host takes the entry at the head with a read strobe. It can see how many entries are waiting and whether a character was lost. When the queue-enable input is low, the store holds only one character. A flush input empties the store, but only while the queue is enabled.

Top module: `serial_rx_path`

## Requirements
- R1: After reset, `data_ready` is 0, `fifo_level` is 0 and `overrun` is 0.
- R2: A low pulse on `rxd` that has ended before the mid-bit check (8 oversample ticks after start detection) is rejected. The receiver returns to idle and nothing is stored.
- R3: A frame is a low start bit, then 8 data bits least significant bit first, an optional parity bit and one stop bit, each 16 ticks long. The stored byte equals the byte sent, and each character raises `fifo_level` by one.
- R4: When `par_en` is 1, the character carries a parity bit. `par_odd` = 0 selects even parity and `par_odd` = 1 selects odd parity. If the parity bit does not match, `rd_perr` is 1 for that entry only.
- R5: If the stop bit is sampled low, `rd_ferr` is 1 for that entry.
- R6: If the data, parity and stop positions are all low, one entry is stored with data 0x00, `rd_brk` = 1 and `rd_ferr` = 1. The line is then ignored until it returns high, so a long break gives a single entry.
- R7: Entries are read in arrival order. Each entry's flags stay with its own byte. `fifo_level` never exceeds 64.
- R8: If a character completes while the store is full and no read occurs in that cycle, `overrun` is set and the new character is dropped. The level and the head entry stay unchanged.
- R9: `overrun` stays 1 until a cycle with `ovr_clr` = 1 clears it.
- R10: `fifo_clr` empties the store in the next cycle when `fifo_en` = 1. When `fifo_en` = 0, `fifo_clr` has no effect.
- R11: With `fifo_en` = 0, the store holds one character. A second character that arrives before the first is read causes an overrun, and the first character is kept.
- R12: A read strobe while the store is empty changes nothing: the level stays 0 and no data appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_en | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input (idle high) |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single holding entry |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_clr | input | 1 | Flush the store (only when fifo_en = 1) |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry data byte (0 when empty) |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break flag |
| data_ready | output | 1 | Store holds at least one entry |
| fifo_level | output | 7 | Number of stored entries |
| overrun | output | 1 | Sticky lost-character flag |

## Verification
The serial input passes through a two-stage synchronizer before the state machine sees it. The stop bit is sampled 8 ticks into its bit time, and the completed entry is registered one cycle later. A character therefore appears in `fifo_level` roughly halfway through its stop bit. The bench keeps the line high for 4 more ticks after each stop bit before it looks, which covers that latency with margin. Flush, pop and overrun-clear take effect at the next clock edge. For these, the bench drives the strobe for one cycle at a falling edge and checks the outputs at a later falling edge.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  localparam int RXP_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_LINEWAIT
  } rxp_state_e;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [RXP_DW-1:0] data;
  } rxp_entry_t;

endpackage

// File: rtl/rxp_sync.sv
module rxp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/rxp_frame.sv
module rxp_frame
  import rxp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxs,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       push_vld,
  output rxp_entry_t push_entry
);

  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(RXP_DW);
  localparam int HALF = OVS / 2;

  rxp_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [RXP_DW-1:0] shf_q, shf_d;
  logic              parb_q, parb_d;
  logic              push_q, push_d;
  rxp_entry_t        ent_q, ent_d;
  logic              at_mid, at_end, exp_par;

  assign at_mid  = tick && (cnt_q == CW'(HALF - 1));
  assign at_end  = tick && (cnt_q == CW'(OVS - 1));
  assign exp_par = (^shf_q) ^ par_odd;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    parb_d  = parb_q;
    push_d  = 1'b0;
    ent_d   = ent_q;
    unique case (state_q)
      ST_IDLE: begin
        if (tick && !rxs) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (at_mid) begin
          cnt_d   = '0;
          bit_d   = '0;
          state_d = rxs ? ST_IDLE : ST_DATA;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (at_end) begin
          cnt_d = '0;
          shf_d = {rxs, shf_q[RXP_DW-1:1]};
          if (bit_q == BW'(RXP_DW - 1)) begin
            state_d = par_en ? ST_PAR : ST_STOP;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (at_end) begin
          cnt_d   = '0;
          parb_d  = rxs;
          state_d = ST_STOP;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (at_end) begin
          cnt_d      = '0;
          push_d     = 1'b1;
          ent_d.data = shf_q;
          ent_d.perr = par_en && (parb_q != exp_par);
          ent_d.ferr = !rxs;
          ent_d.brk  = !rxs && (shf_q == '0) && (!par_en || !parb_q);
          state_d    = rxs ? ST_IDLE : ST_LINEWAIT;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LINEWAIT: begin
        if (rxs) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      parb_q  <= 1'b0;
      push_q  <= 1'b0;
      ent_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      parb_q  <= parb_d;
      push_q  <= push_d;
      ent_q   <= ent_d;
    end
  end

  assign push_vld   = push_q;
  assign push_entry = ent_q;

endmodule

// File: rtl/rxp_store.sv
module rxp_store
  import rxp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic                       clr,
  input  logic                       push,
  input  rxp_entry_t                 push_entry,
  input  logic                       pop_req,
  input  logic                       ovr_clr,
  output rxp_entry_t                 head,
  output logic                       ready,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       overrun
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  rxp_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          ovr_q, ovr_d;
  logic          full, do_clr, do_pop, do_push, ovr_set;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = fifo_en ? (lvl_q == LW'(DEPTH)) : (lvl_q != '0);
    do_clr  = clr && fifo_en;
    do_pop  = pop_req && (lvl_q != '0) && !do_clr;
    do_push = push && !do_clr && (!full || do_pop);
    ovr_set = push && !do_clr && full && !do_pop;

    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (do_clr) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (do_push) wptr_d = wrap_inc(wptr_q);
      if (do_pop)  rptr_d = wrap_inc(rptr_q);
      if (do_push && !do_pop) lvl_d = lvl_q + 1'b1;
      if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
    end

    ovr_d = ovr_q;
    if (ovr_clr)      ovr_d = 1'b0;
    else if (ovr_set) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wptr_q] <= push_entry;
    end
  end

  assign head    = (lvl_q != '0) ? mem_q[rptr_q] : '0;
  assign ready   = (lvl_q != '0);
  assign level   = lvl_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/serial_rx_path.sv
module serial_rx_path
  import rxp_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick16_en,
  input  logic                       rxd,
  input  logic                       fifo_en,
  input  logic                       par_en,
  input  logic                       par_odd,
  input  logic                       fifo_clr,
  input  logic                       ovr_clr,
  input  logic                       rd_en,
  output logic [RXP_DW-1:0]          rd_data,
  output logic                       rd_perr,
  output logic                       rd_ferr,
  output logic                       rd_brk,
  output logic                       data_ready,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  output logic                       overrun
);

  logic       rx_s;
  logic       push_vld;
  rxp_entry_t push_entry;
  rxp_entry_t head;

  rxp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rxd),
    .dout  (rx_s)
  );

  rxp_frame #(.OVS(OVS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16_en),
    .rxs        (rx_s),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .push_vld   (push_vld),
    .push_entry (push_entry)
  );

  rxp_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .clr        (fifo_clr),
    .push       (push_vld),
    .push_entry (push_entry),
    .pop_req    (rd_en),
    .ovr_clr    (ovr_clr),
    .head       (head),
    .ready      (data_ready),
    .level      (fifo_level),
    .overrun    (overrun)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign rd_brk  = head.brk;

endmodule

// File: rtl/rxp_chk.sv
module rxp_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_en,
  input logic                       fifo_clr,
  input logic                       ovr_clr,
  input logic                       rd_en,
  input logic                       push_vld,
  input logic [7:0]                 rd_data,
  input logic                       rd_ferr,
  input logic                       rd_brk,
  input logic                       data_ready,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic                       overrun
);

  localparam int LW = $clog2(DEPTH + 1);

  logic full_now;
  assign full_now = fifo_en ? (fifo_level == LW'(DEPTH)) : (fifo_level != '0);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH)); // R7

  AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && $past(!fifo_en) && ($past(fifo_level) <= 1)) |-> (fifo_level <= 1)); // R11

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && fifo_en) |=> (fifo_level == '0)); // R10

  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && full_now && !rd_en && !(fifo_clr && fifo_en))
      |=> (overrun && $stable(fifo_level))); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun); // R9

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (fifo_level == '0) && !push_vld) |=> (fifo_level == '0)); // R12

  AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_brk) |-> ((rd_data == 8'h00) && rd_ferr)); // R6

endmodule

bind serial_rx_path rxp_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .fifo_clr   (fifo_clr),
  .ovr_clr    (ovr_clr),
  .rd_en      (rd_en),
  .push_vld   (push_vld),
  .rd_data    (rd_data),
  .rd_ferr    (rd_ferr),
  .rd_brk     (rd_brk),
  .data_ready (data_ready),
  .fifo_level (fifo_level),
  .overrun    (overrun)
);

// File: tb/serial_rx_path_tb.sv
module serial_rx_path_tb;

  localparam int TD = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16_en = 1'b0;
  logic       rxd = 1'b1;
  logic       fifo_en = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       fifo_clr = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun;
  logic [6:0] fifo_level;

  int total = 0;
  int bad = 0;
  int div = 0;
  bit done = 0;

  serial_rx_path u_dut (
    .clk(clk), .rst_n(rst_n), .tick16_en(tick16_en), .rxd(rxd),
    .fifo_en(fifo_en), .par_en(par_en), .par_odd(par_odd),
    .fifo_clr(fifo_clr), .ovr_clr(ovr_clr), .rd_en(rd_en),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .data_ready(data_ready), .fifo_level(fifo_level), .overrun(overrun)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (div == TD - 1) begin
      div = 0;
      tick16_en = 1'b1;
    end else begin
      div = div + 1;
      tick16_en = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TD) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    wait_ticks(16);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop_v);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (par_en) send_bit(((^d) ^ par_odd) ^ flip);
    send_bit(stop_v);
    rxd = 1'b1;
    wait_ticks(4);
  endtask

  task automatic pulse_cycle(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_check(input string req, input logic [7:0] d,
                           input logic pe, input logic fe, input logic bk);
    chk({req, " ready"}, data_ready, 1);
    chk({req, " data"}, rd_data, d);
    chk({req, " perr"}, rd_perr, pe);
    chk({req, " ferr"}, rd_ferr, fe);
    chk({req, " brk"}, rd_brk, bk);
    pulse_cycle(rd_en);
  endtask

  task automatic t_reset;
    chk("R1 ready", data_ready, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_false_start;
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(40);
    chk("R2 level", fifo_level, 0);
  endtask

  task automatic t_basic;
    par_en = 0;
    send_frame(8'hA5, 0, 1);
    chk("R3 level1", fifo_level, 1);
    send_frame(8'h3C, 0, 1);
    send_frame(8'h01, 0, 1);
    chk("R3 level3", fifo_level, 3);
    pop_check("R3", 8'hA5, 0, 0, 0);
    pop_check("R7 order", 8'h3C, 0, 0, 0);
    pop_check("R7 order", 8'h01, 0, 0, 0);
    chk("R3 empty", fifo_level, 0);
  endtask

  task automatic t_parity;
    par_en = 1;
    par_odd = 0;
    send_frame(8'h5A, 0, 1);
    send_frame(8'h5A, 1, 1);
    par_odd = 1;
    send_frame(8'h07, 0, 1);
    send_frame(8'h07, 1, 1);
    pop_check("R4 even ok", 8'h5A, 0, 0, 0);
    pop_check("R4 even bad", 8'h5A, 1, 0, 0);
    pop_check("R4 odd ok", 8'h07, 0, 0, 0);
    pop_check("R4 odd bad", 8'h07, 1, 0, 0);
    par_en = 0;
    par_odd = 0;
  endtask

  task automatic t_framing;
    send_frame(8'h81, 0, 0);
    send_frame(8'h42, 0, 1);
    pop_check("R5 ferr", 8'h81, 0, 1, 0);
    pop_check("R7 flags own byte", 8'h42, 0, 0, 0);
  endtask

  task automatic t_break;
    rxd = 1'b0;
    wait_ticks(16 * 10 + 40);
    rxd = 1'b1;
    wait_ticks(24);
    chk("R6 one entry", fifo_level, 1);
    pop_check("R6 break", 8'h00, 0, 1, 1);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 64; i++) send_frame(8'(i * 3 + 1), 0, 1);
    chk("R7 full level", fifo_level, 64);
    chk("R8 no ovr yet", overrun, 0);
    send_frame(8'hEE, 0, 1);
    chk("R8 overrun", overrun, 1);
    chk("R8 level kept", fifo_level, 64);
    chk("R8 head kept", rd_data, 8'h01);
    for (int i = 0; i < 64; i++) pop_check("R7 drain", 8'(i * 3 + 1), 0, 0, 0);
    chk("R8 dropped char", fifo_level, 0);
    chk("R9 sticky", overrun, 1);
    pulse_cycle(ovr_clr);
    chk("R9 cleared", overrun, 0);
  endtask

  task automatic t_clear;
    send_frame(8'h10, 0, 1);
    send_frame(8'h20, 0, 1);
    fifo_en = 0;
    pulse_cycle(fifo_clr);
    chk("R10 clr ignored", fifo_level, 2);
    chk("R10 head kept", rd_data, 8'h10);
    fifo_en = 1;
    pulse_cycle(fifo_clr);
    chk("R10 clr empties", fifo_level, 0);
    chk("R10 ready low", data_ready, 0);
  endtask

  task automatic t_hold;
    fifo_en = 0;
    send_frame(8'h11, 0, 1);
    chk("R11 one held", fifo_level, 1);
    chk("R11 no ovr", overrun, 0);
    send_frame(8'h22, 0, 1);
    chk("R11 overrun", overrun, 1);
    chk("R11 level", fifo_level, 1);
    pop_check("R11 first kept", 8'h11, 0, 0, 0);
    chk("R11 empty", fifo_level, 0);
    pulse_cycle(ovr_clr);
    fifo_en = 1;
  endtask

  task automatic t_empty_read;
    pulse_cycle(rd_en);
    chk("R12 level", fifo_level, 0);
    chk("R12 ready", data_ready, 0);
    chk("R12 data", rd_data, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_false_start();
    t_basic();
    t_parity();
    t_framing();
    t_break();
    t_overrun();
    t_clear();
    t_hold();
    t_empty_read();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule